// File: doc/BRIEF.md
# Codec Identity Strapping and Chain-In Output Select

This block gives a serial audio codec its identity on a shared link. Two active-low strap pins are brought in through a synchronizer and inverted to form a two-bit identity. An identity of zero marks the codec as the primary, which drives the link bit clock. Any other identity marks it as a secondary, which receives the bit clock from outside. The identity can be read back in the upper field of a read-only register.

A second, writable register holds a two-bit chain field. After a cold reset this field tracks the identity, so the codec drives its own status stream onto the serial output. When software writes a chain value that differs from the identity, the output switches to a pass-through of the chain input pin. This lets codecs be daisy-chained onto one return line. Writing the identity back into the field restores the codec's own stream.

The block is driven from the crystal clock. It also produces the divided bit clock and its output enable.

Top module: `cic_ident_chain`

## Requirements
- R1: The identity is the bitwise inverse of `strap_n`, valid two clock edges after the pins settle. A read of index 28h returns it in bits 15:14, with every other bit zero.
- R2: `is_primary` is high exactly when the identity is 00.
- R3: From a cold reset until the first write to index 74h, a read of 74h returns the current identity in bits 1:0, and the output is not in pass-through.
- R4: A write to index 74h stores data bits 1:0 and discards the rest. A read of 74h then returns them in bits 1:0, with zeros in bits 15:2.
- R5: When the chain field differs from the identity, `sdata_out` equals `chain_in`. Otherwise it equals `own_sdata`.
- R6: Writing the current identity into index 74h ends pass-through.
- R7: Writes to index 28h change neither the identity readback nor the chain field.
- R8: When primary, `bclk_oe` is high and `bclk` toggles on every clock edge, giving half the crystal rate. When secondary, `bclk_oe` is low and `bclk` stays low.
- R9: Driving `rst_n` low acts at once, without a clock edge. It returns the chain field to tracking the identity, clears pass-through and parks `bclk` low.
- R10: Indices other than 28h and 74h read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| strap_n | input | 2 | Active-low identity strap pins |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 7 | Register index for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_idx` (combinational) |
| own_sdata | input | 1 | The codec's own serial status stream |
| chain_in | input | 1 | Serial stream from the downstream codec |
| sdata_out | output | 1 | Serial data toward the controller |
| is_primary | output | 1 | High when the identity is 00 |
| bclk | output | 1 | Divided bit clock |
| bclk_oe | output | 1 | Bit clock output enable |

## Verification
The hardest state to reach is a chain field that no longer tracks the identity while the straps move underneath it. The stimulus reaches it by writing every chain value under every strap setting, then changing the straps after a write. Pass-through must then appear or vanish without any further register access. The asynchronous reset is applied in the middle of the low clock phase while pass-through is active. The outputs are checked before the next clock edge.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;
   // role decoded from the synchronized identity
   typedef enum logic {
      ROLE_PRIMARY   = 1'b0,
      ROLE_SECONDARY = 1'b1
   } cic_role_e;

   localparam int CIC_IDX_W    = 7;
   localparam int CIC_DATA_W   = 16;
   localparam int CIC_ID_W     = 2;
   localparam int CIC_ID_LSB   = 14;
   localparam logic [CIC_IDX_W-1:0] CIC_ID_IDX    = 7'h28;
   localparam logic [CIC_IDX_W-1:0] CIC_CHAIN_IDX = 7'h74;
endpackage

// File: rtl/cic_strap_sync.sv
`timescale 1ns/1ps
module cic_strap_sync #(
   parameter int ID_W   = 2,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] strap_n_i,
   output logic [ID_W-1:0] ident_o
);
   localparam int CNT_W = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("cic_strap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][ID_W-1:0] stage_q;

   // idle straps (pulled high) decode to identity zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '1;
      else        stage_q <= {stage_q[STAGES-2:0], strap_n_i};
   end

   assign ident_o = ~stage_q[STAGES-1];

   if (STAGES == 2) begin : g_chk_two
      logic [CNT_W-1:0] up_cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              up_cnt_q <= '0;
         else if (up_cnt_q != '1) up_cnt_q <= up_cnt_q + 1'b1;
      end
      assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (up_cnt_q == '1) |-> (ident_o == ~$past(strap_n_i, 2)));
   end
endmodule

// File: rtl/cic_chain_reg.sv
`timescale 1ns/1ps
module cic_chain_reg #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 16,
   parameter int ID_W   = 2,
   parameter int ID_LSB = 14,
   parameter logic [IDX_W-1:0] ID_IDX    = 7'h28,
   parameter logic [IDX_W-1:0] CHAIN_IDX = 7'h74
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [ID_W-1:0]   wdata_i,
   input  logic [ID_W-1:0]   ident_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ID_W-1:0]   chain_o
);
   logic            follow_q;
   logic [ID_W-1:0] chain_q;
   logic            seen_q;
   logic            chain_hit;

   assign chain_hit = wr_en_i && (idx_i == CHAIN_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         follow_q <= 1'b1;
         chain_q  <= '0;
         seen_q   <= 1'b0;
      end else begin
         seen_q <= 1'b1;
         if (chain_hit) begin
            follow_q <= 1'b0;
            chain_q  <= wdata_i;
         end
      end
   end

   // until software writes the field, it mirrors the identity
   assign chain_o = follow_q ? ident_i : chain_q;

   always_comb begin
      rdata_o = '0;
      if (idx_i == ID_IDX)         rdata_o[ID_LSB +: ID_W] = ident_i;
      else if (idx_i == CHAIN_IDX) rdata_o[ID_W-1:0]       = chain_o;
   end

   assert_chain_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(chain_hit)) |-> (!follow_q && chain_q == $past(wdata_i)));

   assert_ro_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(wr_en_i && idx_i == ID_IDX)) |->
      (chain_q == $past(chain_q) && follow_q == $past(follow_q)));
endmodule

// File: rtl/cic_bclk_gen.sv
`timescale 1ns/1ps
module cic_bclk_gen
   import cic_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  cic_role_e role_i,
   output logic      bclk_o,
   output logic      bclk_oe_o
);
   logic bclk_q;
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         seen_q <= 1'b1;
         bclk_q <= (role_i == ROLE_PRIMARY) ? ~bclk_q : 1'b0;
      end
   end

   assign bclk_o    = bclk_q;
   assign bclk_oe_o = (role_i == ROLE_PRIMARY);

   assert_bclk_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(role_i) == ROLE_PRIMARY) |-> (bclk_q != $past(bclk_q)));

   assert_bclk_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(role_i) == ROLE_SECONDARY) |-> !bclk_q);
endmodule

// File: rtl/cic_ident_chain.sv
`timescale 1ns/1ps
module cic_ident_chain
   import cic_pkg::*;
#(
   parameter int IDX_W       = CIC_IDX_W,
   parameter int DATA_W      = CIC_DATA_W,
   parameter int ID_W        = CIC_ID_W,
   parameter int ID_LSB      = CIC_ID_LSB,
   parameter int SYNC_STAGES = 2,
   parameter logic [IDX_W-1:0] ID_IDX    = CIC_ID_IDX,
   parameter logic [IDX_W-1:0] CHAIN_IDX = CIC_CHAIN_IDX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   strap_n,
   input  logic              reg_wr,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              own_sdata,
   input  logic              chain_in,
   output logic              sdata_out,
   output logic              is_primary,
   output logic              bclk,
   output logic              bclk_oe
);
   localparam int ID_MSB = ID_LSB + ID_W - 1;

   if (ID_MSB >= DATA_W) begin : g_bad_field
      $error("cic_ident_chain: identity field exceeds data width");
   end
   if (ID_IDX == CHAIN_IDX) begin : g_bad_idx
      $error("cic_ident_chain: register indices collide");
   end
   if (ID_W >= DATA_W) begin : g_bad_idw
      $error("cic_ident_chain: chain field wider than data");
   end

   logic [ID_W-1:0] ident;
   logic [ID_W-1:0] chain;
   logic            pass_thru;
   cic_role_e       role;
   logic            unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:ID_W];

   cic_strap_sync #(.ID_W(ID_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_n_i (strap_n),
      .ident_o   (ident)
   );

   cic_chain_reg #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W), .ID_LSB(ID_LSB),
      .ID_IDX(ID_IDX), .CHAIN_IDX(CHAIN_IDX)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (reg_wr),
      .idx_i   (reg_idx),
      .wdata_i (reg_wdata[ID_W-1:0]),
      .ident_i (ident),
      .rdata_o (reg_rdata),
      .chain_o (chain)
   );

   assign role       = (ident == '0) ? ROLE_PRIMARY : ROLE_SECONDARY;
   assign is_primary = (role == ROLE_PRIMARY);

   cic_bclk_gen u_bclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .role_i    (role),
      .bclk_o    (bclk),
      .bclk_oe_o (bclk_oe)
   );

   // a mismatch between field and identity selects the chain pin
   assign pass_thru = (chain != ident);
   assign sdata_out = pass_thru ? chain_in : own_sdata;

   assert_oe_role_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bclk_oe == (reg_idx == ID_IDX ? (reg_rdata[ID_MSB:ID_LSB] == '0) : bclk_oe));
endmodule

// File: tb/cic_ident_chain_tb.sv
`timescale 1ns/1ps
module cic_ident_chain_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap_n = 2'b11;
   logic        reg_wr = 1'b0;
   logic [6:0]  reg_idx = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        own_sdata = 1'b0;
   logic        chain_in = 1'b0;
   logic        sdata_out;
   logic        is_primary;
   logic        bclk;
   logic        bclk_oe;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cic_ident_chain u_dut (
      .clk(clk), .rst_n(rst_n), .strap_n(strap_n),
      .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .own_sdata(own_sdata), .chain_in(chain_in),
      .sdata_out(sdata_out), .is_primary(is_primary),
      .bclk(bclk), .bclk_oe(bclk_oe)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [6:0] i, output logic [15:0] d);
      reg_idx = i;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [6:0] i, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_ident(input logic [1:0] id);
      @(negedge clk);
      strap_n = ~id;
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_mux(input string req, input bit exp_pass);
      for (int o = 0; o < 2; o++) begin
         for (int c = 0; c < 2; c++) begin
            own_sdata = o[0]; chain_in = c[0];
            #0.25;
            chk(req, {15'b0, sdata_out}, {15'b0, exp_pass ? c[0] : o[0]});
         end
      end
   endtask

   task automatic chk_bclk(input bit prim);
      logic prev;
      @(negedge clk);
      prev = bclk;
      chk("R8 oe", {15'b0, bclk_oe}, {15'b0, prim});
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R8 bclk", {15'b0, bclk}, {15'b0, prim ? ~prev : 1'b0});
         prev = bclk;
      end
   endtask

   initial begin : watchdog
      #400000;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [15:0] d;
      // reset state
      #5;
      rd(7'h74, d); chk("R9 reset chain", d, 16'h0000);
      chk("R9 reset primary", {15'b0, is_primary}, 16'h0001);
      chk("R9 reset bclk", {15'b0, bclk}, 16'h0000);
      #4 rst_n = 1'b1;

      // strap sweep with the chain field still tracking
      for (int s = 0; s < 4; s++) begin
         set_ident(s[1:0]);
         rd(7'h28, d); chk("R1 ident", d, {s[1:0], 14'b0});
         chk("R2 primary", {15'b0, is_primary}, {15'b0, s == 0});
         rd(7'h74, d); chk("R3 follow", d, {14'b0, s[1:0]});
         chk_mux("R3 no pass", 1'b0);
         chk_bclk(s == 0);
      end

      // every chain value under every identity
      for (int s = 0; s < 4; s++) begin
         set_ident(s[1:0]);
         for (int c = 0; c < 4; c++) begin
            wr(7'h74, 16'hFFFC | 16'(c));
            rd(7'h74, d); chk("R4 chain rd", d, {14'b0, c[1:0]});
            chk_mux("R5 mux", c != s);
         end
         wr(7'h74, 16'(s));
         chk_mux("R6 restore", 1'b0);
      end

      // read-only identity register
      set_ident(2'd2);
      wr(7'h74, 16'h0001);
      wr(7'h28, 16'h0000);
      wr(7'h28, 16'hFFFF);
      @(negedge clk);
      rd(7'h28, d); chk("R7 ident kept", d, 16'h8000);
      rd(7'h74, d); chk("R7 chain kept", d, 16'h0001);
      chk_mux("R7 pass kept", 1'b1);

      // strap change after a write: field no longer tracks
      set_ident(2'd1);
      chk_mux("R5 strap now matches", 1'b0);
      set_ident(2'd3);
      chk_mux("R5 strap mismatch", 1'b1);

      // unmapped indices
      wr(7'h75, 16'h0003);
      wr(7'h00, 16'hFFFF);
      @(negedge clk);
      rd(7'h75, d); chk("R10 rd 75", d, 16'h0000);
      rd(7'h00, d); chk("R10 rd 00", d, 16'h0000);
      rd(7'h74, d); chk("R10 chain kept", d, 16'h0001);

      // asynchronous reset in the low phase while passing through
      wr(7'h74, 16'h0000);
      chk_mux("R9 pre pass", 1'b1);
      @(negedge clk);
      #0.5 rst_n = 1'b0;
      rd(7'h74, d); chk("R9 async chain", d, 16'h0000);
      chk("R9 async primary", {15'b0, is_primary}, 16'h0001);
      chk("R9 async bclk", {15'b0, bclk}, 16'h0000);
      chk_mux("R9 async no pass", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd(7'h74, d); chk("R3 after reset", d, 16'h0003);
      chk_mux("R3 after reset no pass", 1'b0);
      chk("R2 secondary", {15'b0, is_primary}, 16'h0000);
      chk_bclk(1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule